// File: doc/BRIEF.md
# External Pin Interrupt Controller

This block watches six external interrupt pins, turns their activity into per-source request flags, and reports to a CPU core whether an enabled interrupt is pending. When one is pending, it also reports that interrupt's priority level and its source number. Each pin is first passed through a two-flop synchronizer. A 2-bit trigger code per pin then chooses how the pin is interpreted: low-level, high-level, falling-edge or rising-edge. In edge modes, an event latches a request flag that stays set until software clears it. In level modes, the flag follows the pin.

Software programs the block over a byte-wide register bus. A 16-bit mode register holds all trigger codes. Each source also has a pair of control bytes. The low byte carries the request flag and a sticky detect flag. The high byte carries a 3-bit priority and an enable bit. The arbiter picks the highest priority among sources that are flagged, enabled and not at level 0. When two such sources share the highest level, the lower-numbered source wins. The result is registered before it reaches the core.

Top module: `extint_ctrl`

## Requirements
- R1: After a synchronous reset, all of the following are 0: every trigger code, request flag, detect flag, enable and priority, `irq_req`, `irq_level` and `irq_id`.
- R2: The mode register is at byte 0xFCF8 (bits 7:0) and byte 0xFCF9 (bits 15:8). Pin n uses bits 2n+1:2n. Bits 15:12 ignore writes and read as 0.
- R3: Trigger code 00 (active-low level) and code 01 (active-high level) make the request flag follow the synchronized pin. Bus writes to the flag have no effect in these modes.
- R4: Code 10 sets the request flag on a falling edge of the synchronized pin, and code 11 sets it on a rising edge. The flag stays set until software writes a 0 to bit 4 of the source's low control byte. The opposite edge does not set it.
- R5: The control bytes for source n are at 0xFC48+2n (low) and 0xFC49+2n (high). In the high byte, the priority is in bits 6:4 and the enable is in bit 0; for example, 0x51 gives priority 5, enabled. Other bits read as 0.
- R6: Bit 0 of the low byte is a detect flag. It is set by any change of the synchronized pin, whatever the mode or enable. Writing 0 to a flag clears it, and writing 1 leaves it unchanged.
- R7: `irq_req` is 1 exactly when some source has its request flag set, its enable bit set and a nonzero priority. A source at priority 0 is masked.
- R8: `irq_level` is the highest priority among the active sources, and `irq_id` is the lowest-numbered active source at that level. Both are 0 when `irq_req` is 0.
- R9: A pin change reaches `irq_req` after the two-flop synchronizer, the edge stage, the flag register and the output register. The output is settled no later than 5 clocks after the change.
- R10: `bus_rdata` is registered. It shows the register selected by `bus_addr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 6 | Asynchronous external interrupt pins |
| bus_addr | input | 16 | Byte address for reads and writes |
| bus_wr | input | 1 | Write strobe for one byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_req | output | 1 | Registered interrupt request to the core |
| irq_level | output | 3 | Priority of the winning source |
| irq_id | output | 3 | Number of the winning source |

## Verification
The bench builds the block with its defaults: six sources, 3-bit priorities and the standard addresses. With these values, all four trigger codes and the high mode byte with its unused upper bits can be exercised. The priority width also allows both the masked level 0 and the top level 7. The bench programs pin 0 for falling edges at priority 5. It checks that a request appears only after a 1-to-0 transition and that it stays latched until software writes a 0. It then checks level following, disabling, masking, priority ties and the sticky behaviour of the detect flag.

// File: rtl/extint_pkg.sv
package extint_pkg;
  typedef enum logic [1:0] {
    TRIG_LVL_LO = 2'b00,
    TRIG_LVL_HI = 2'b01,
    TRIG_FALL   = 2'b10,
    TRIG_RISE   = 2'b11
  } trig_e;

  localparam int REQ_BIT = 4;
  localparam int DET_BIT = 0;
  localparam int EN_BIT  = 0;
  localparam int PRIO_LSB = 4;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_now,
  output logic [W-1:0] pin_prev
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  // Reset to the idle-high state so released pins raise no event.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '1;
      s2_q <= '1;
      s3_q <= '1;
    end else begin
      s1_q <= pin_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign pin_now  = s2_q;
  assign pin_prev = s3_q;
endmodule

// File: rtl/extint_chan.sv
module extint_chan
  import extint_pkg::*;
#(
  parameter int PRIO_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_now,
  input  logic              pin_prev,
  input  logic [1:0]        trig,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [7:0]        wdata,
  output logic              req_q,
  output logic              det_q,
  output logic              en_q,
  output logic [PRIO_W-1:0] prio_q
);
  trig_e mode;
  logic  is_level, lvl_act, edge_hit, changed, clr_req, clr_det;

  always_comb begin
    mode     = trig_e'(trig);
    is_level = (mode == TRIG_LVL_LO) || (mode == TRIG_LVL_HI);
    lvl_act  = (mode == TRIG_LVL_HI) ? pin_now : ~pin_now;
    changed  = pin_now ^ pin_prev;
    case (mode)
      TRIG_FALL: edge_hit = pin_prev & ~pin_now;
      TRIG_RISE: edge_hit = ~pin_prev & pin_now;
      default:   edge_hit = 1'b0;
    endcase
    clr_req = wr_lo & ~wdata[REQ_BIT];
    clr_det = wr_lo & ~wdata[DET_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      det_q  <= 1'b0;
      en_q   <= 1'b0;
      prio_q <= '0;
    end else begin
      if (is_level)       req_q <= lvl_act;
      else if (edge_hit)  req_q <= 1'b1;
      else if (clr_req)   req_q <= 1'b0;

      if (changed)        det_q <= 1'b1;
      else if (clr_det)   det_q <= 1'b0;

      if (wr_hi) begin
        en_q   <= wdata[EN_BIT];
        prio_q <= wdata[PRIO_LSB +: PRIO_W];
      end
    end
  end

  // R4: a latched edge request survives until cleared or the mode turns level
  p_edge_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!is_level && req_q && !clr_req) |=> (req_q || (trig[1] == 1'b0)));

  // R6: a pin change always leaves the detect flag set
  p_det_on_change_r6: assert property (@(posedge clk) disable iff (rst)
    changed |=> det_q);
endmodule

// File: rtl/extint_arb.sv
module extint_arb #(
  parameter int N      = 6,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 3
) (
  input  logic [N-1:0]             act,
  input  logic [N-1:0][PRIO_W-1:0] prio,
  output logic                     any,
  output logic [PRIO_W-1:0]        win_lvl,
  output logic [ID_W-1:0]          win_id
);
  always_comb begin
    any     = 1'b0;
    win_lvl = '0;
    win_id  = '0;
    // Strict compare, ascending index: ties keep the lower source.
    for (int i = 0; i < N; i++) begin
      if (act[i] && (prio[i] > win_lvl)) begin
        any     = 1'b1;
        win_lvl = prio[i];
        win_id  = ID_W'(i);
      end
    end
  end

  // R8: the winner number always names an existing source
  always_comb begin
    p_id_range_r8: assert (int'(win_id) < N);
  end
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int NUM_SRC   = 6,
  parameter int PRIO_W    = 3,
  parameter int ADDR_W    = 16,
  parameter int MODE_ADDR = 'hFCF8,
  parameter int CTRL_BASE = 'hFC48
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_SRC-1:0]         ext_pin,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_wr,
  input  logic [7:0]                 bus_wdata,
  output logic [7:0]                 bus_rdata,
  output logic                       irq_req,
  output logic [PRIO_W-1:0]          irq_level,
  output logic [$clog2(NUM_SRC)-1:0] irq_id
);
  localparam int ID_W      = $clog2(NUM_SRC);
  localparam int MODE_BITS = 2 * NUM_SRC;
  localparam logic [ADDR_W-1:0] M_LO = ADDR_W'(MODE_ADDR);
  localparam logic [ADDR_W-1:0] M_HI = ADDR_W'(MODE_ADDR + 1);

  logic [NUM_SRC-1:0]             pin_now, pin_prev;
  logic [MODE_BITS-1:0]           mode_q;
  logic [15:0]                    mode16;
  logic [NUM_SRC-1:0]             req, det, en, act, sel_lo, sel_hi;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
  logic                           any;
  logic [PRIO_W-1:0]              win_lvl;
  logic [ID_W-1:0]                win_id;
  logic [7:0]                     rd_mux;

  extint_sync #(.W(NUM_SRC)) u_sync (
    .clk(clk), .rst(rst), .pin_in(ext_pin),
    .pin_now(pin_now), .pin_prev(pin_prev)
  );

  // Mode register, bits above MODE_BITS do not exist.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
    end else if (bus_wr) begin
      for (int b = 0; b < MODE_BITS; b++) begin
        if (b < 8 && bus_addr == M_LO) mode_q[b] <= bus_wdata[b % 8];
        if (b >= 8 && bus_addr == M_HI) mode_q[b] <= bus_wdata[b % 8];
      end
    end
  end
  assign mode16 = 16'(mode_q);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(CTRL_BASE + 2 * i);
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(CTRL_BASE + 2 * i + 1);
    assign sel_lo[i] = (bus_addr == A_LO);
    assign sel_hi[i] = (bus_addr == A_HI);

    extint_chan #(.PRIO_W(PRIO_W)) u_chan (
      .clk(clk), .rst(rst),
      .pin_now(pin_now[i]), .pin_prev(pin_prev[i]),
      .trig(mode_q[2*i +: 2]),
      .wr_lo(bus_wr & sel_lo[i]), .wr_hi(bus_wr & sel_hi[i]),
      .wdata(bus_wdata),
      .req_q(req[i]), .det_q(det[i]), .en_q(en[i]), .prio_q(prio[i])
    );
    assign act[i] = req[i] & en[i] & (prio[i] != '0);
  end

  extint_arb #(.N(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
    .act(act), .prio(prio), .any(any), .win_lvl(win_lvl), .win_id(win_id)
  );

  always_comb begin
    rd_mux = 8'h00;
    if (bus_addr == M_LO) rd_mux = mode16[7:0];
    if (bus_addr == M_HI) rd_mux = mode16[15:8];
    for (int i = 0; i < NUM_SRC; i++) begin
      if (sel_lo[i]) begin
        rd_mux          = 8'h00;
        rd_mux[REQ_BIT] = req[i];
        rd_mux[DET_BIT] = det[i];
      end
      if (sel_hi[i]) begin
        rd_mux                        = 8'h00;
        rd_mux[EN_BIT]                = en[i];
        rd_mux[PRIO_LSB +: PRIO_W]    = prio[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= 8'h00;
      irq_req   <= 1'b0;
      irq_level <= '0;
      irq_id    <= '0;
    end else begin
      bus_rdata <= rd_mux;
      irq_req   <= any;
      irq_level <= win_lvl;
      irq_id    <= win_id;
    end
  end

  // R7: a request to the core never carries the masked level
  p_req_level_r7: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_level != '0));

  // R8: idle outputs are zero
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !irq_req |-> (irq_level == '0 && irq_id == '0));

  // R2: unused top bits of the mode register read back as zero
  p_mode_hi_zero_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == M_HI) |-> (bus_rdata[7:4] == 4'h0));
endmodule

// File: tb/extint_ctrl_tb.sv
module extint_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  ext_pin = 6'h3F;
  logic [15:0] bus_addr = 16'h0000;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic        irq_req;
  logic [2:0]  irq_level;
  logic [2:0]  irq_id;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  extint_ctrl u_dut (
    .clk(clk), .rst(rst), .ext_pin(ext_pin), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .irq_level(irq_level), .irq_id(irq_id)
  );

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [7:0]  wd;
    logic [5:0]  pins;
    logic        req;
    logic [2:0]  lvl;
    logic [2:0]  id;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'hFCF8, 8'h02, 6'h3F, 1'b0, 3'd0, 3'd0}, // 0 R2 pin0 falling
    '{1'b1, 16'hFC49, 8'h51, 6'h3F, 1'b0, 3'd0, 3'd0}, // 1 R5 prio5 enabled, no edge
    '{1'b0, 16'h0000, 8'h00, 6'h3E, 1'b1, 3'd5, 3'd0}, // 2 R4 falling edge
    '{1'b0, 16'h0000, 8'h00, 6'h3F, 1'b1, 3'd5, 3'd0}, // 3 R4 latched after rise
    '{1'b1, 16'hFC48, 8'h00, 6'h3F, 1'b0, 3'd0, 3'd0}, // 4 R4 software clear
    '{1'b0, 16'h0000, 8'h00, 6'h3F, 1'b0, 3'd0, 3'd0}, // 5 R4 stays clear
    '{1'b0, 16'h0000, 8'h00, 6'h3E, 1'b1, 3'd5, 3'd0}, // 6 R9 second falling edge
    '{1'b1, 16'hFC48, 8'h00, 6'h3E, 1'b0, 3'd0, 3'd0}, // 7 R4 clear while low
    '{1'b1, 16'hFC4B, 8'h71, 6'h3C, 1'b1, 3'd7, 3'd1}, // 8 R3 pin1 low level, prio7
    '{1'b0, 16'h0000, 8'h00, 6'h3E, 1'b0, 3'd0, 3'd0}, // 9 R3 level follows pin
    '{1'b1, 16'hFCF8, 8'h06, 6'h3E, 1'b1, 3'd7, 3'd1}, // 10 R3 pin1 high level
    '{1'b1, 16'hFC4B, 8'h70, 6'h3E, 1'b0, 3'd0, 3'd0}, // 11 R7 disabled
    '{1'b1, 16'hFC4D, 8'h31, 6'h3A, 1'b1, 3'd3, 3'd2}, // 12 R7 source2 prio3
    '{1'b1, 16'hFC4D, 8'h01, 6'h3A, 1'b0, 3'd0, 3'd0}, // 13 R7 prio0 masked
    '{1'b1, 16'hFC4D, 8'h31, 6'h3A, 1'b1, 3'd3, 3'd2}, // 14 R7 unmasked again
    '{1'b1, 16'hFC4F, 8'h31, 6'h32, 1'b1, 3'd3, 3'd2}, // 15 R8 tie to lower id
    '{1'b1, 16'hFC4D, 8'h21, 6'h32, 1'b1, 3'd3, 3'd3}  // 16 R8 higher level wins
  };

  task automatic chk_irq(input string tag, input logic r, input logic [2:0] l,
                         input logic [2:0] i);
    n_vec++;
    if (irq_req !== r || irq_level !== l || irq_id !== i) begin
      n_bad++;
      $display("FAIL %s: got req=%0b lvl=%0d id=%0d, want req=%0b lvl=%0d id=%0d",
               tag, irq_req, irq_level, irq_id, r, l, i);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic chk_read(input string tag, input logic [15:0] a, input logic [7:0] exp);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    n_vec++;
    if (bus_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s: read %h got %h want %h", tag, a, bus_rdata, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_irq("R1 reset outputs", 1'b0, 3'd0, 3'd0);
    chk_read("R1 reset high byte", 16'hFC49, 8'h00);
    chk_read("R1 reset mode", 16'hFCF8, 8'h00);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      ext_pin = VECS[v].pins;
      if (VECS[v].wr) begin
        bus_addr = VECS[v].addr; bus_wdata = VECS[v].wd; bus_wr = 1'b1;
      end
      @(negedge clk);
      bus_wr = 1'b0;
      repeat (5) @(negedge clk);
      chk_irq($sformatf("vector %0d", v), VECS[v].req, VECS[v].lvl, VECS[v].id);
    end

    // R5 high byte readback, R10 registered read
    chk_read("R5 source0 high byte", 16'hFC49, 8'h51);
    chk_read("R10 source2 high byte", 16'hFC4D, 8'h21);
    // R2 mode high byte: only bits 11:8 exist
    bus_write(16'hFCF9, 8'hFF);
    chk_read("R2 mode high byte", 16'hFCF9, 8'h0F);
    chk_read("R2 mode low byte", 16'hFCF8, 8'h06);
    // pin4 now rising-edge, disabled: falling edge sets only detect (R4, R6)
    @(negedge clk); ext_pin = 6'h22;
    repeat (6) @(negedge clk);
    chk_read("R4 falling ignored in rising mode", 16'hFC50, 8'h01);
    @(negedge clk); ext_pin = 6'h32;
    repeat (6) @(negedge clk);
    chk_read("R4 rising edge latched", 16'hFC50, 8'h11);
    chk_irq("R7 disabled source not reported", 1'b1, 3'd3, 3'd3);
    bus_write(16'hFC50, 8'hFF);
    chk_read("R6 writing ones keeps flags", 16'hFC50, 8'h11);
    bus_write(16'hFC50, 8'h00);
    chk_read("R6 writing zeros clears flags", 16'hFC50, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout want completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule